// File: doc/BRIEF.md
# Credit-Based Link Flow Controller

This block carries fixed-width flits across one point-to-point link and keeps the far-end buffer from ever overflowing, using window-style credits. The transmit half holds a credit counter that starts out equal to the depth of the receive buffer. Each flit it launches costs one credit, and it refuses new flits while the counter is empty. The receive half stores arriving flits in a FIFO and hands them to a local consumer through a valid/ready port. It counts the slots that the consumer frees and sends them back to the transmit half over a return channel with a fixed latency.

The freed slots do not go back one by one. A small state machine, the bundler, gathers them and emits one return message with a 4-bit credit count. It emits when the number pending reaches a bundle threshold, or when a gathering window of a set length expires with at least one slot pending. The bundler has three states: `BND_IDLE` (nothing pending), `BND_GATHER` (slots pending, window timer running) and `BND_EMIT` (return message on the channel for one cycle). Its transitions are: *release* to `BND_EMIT` when the threshold or the timeout is met; *collect* to `BND_GATHER` when slots are pending without a release; *settle* to `BND_IDLE` when nothing is pending. The transmit half has two states. In `SND_RUN` credits are left. In `SND_WAIT` the pool is empty. It goes *exhaust* from run to wait when a send spends the last credit, and *refill* from wait to run when a return message arrives.

The pool has to cover the full round trip: the forward register, the FIFO write, the bundling window and the return-channel stages. If the pool is too small, the link stalls even though the consumer is draining.

Top module: `cfc_link`

## Requirements
- R1: After reset the transmit pool holds DEPTH credits, `in_ready` is 1 and `out_valid` is 0.
- R2: Each accepted flit (`in_valid` and `in_ready` at a clock edge) spends exactly one credit. With no draining, exactly DEPTH flits are accepted before `in_ready` falls.
- R3: While the pool is empty and no return message is arriving, `in_ready` is 0 and no flit is accepted.
- R4: Flits come out at `out_data` in the order they were accepted, unchanged, and `out_valid` is 0 once all of them have been consumed.
- R5: When the freed-slot count reaches BUNDLE, one return message carrying exactly BUNDLE credits is released. It leaves on the clock edge of the pop that completes the bundle, and its credits become usable LINK_DELAY edges after that pop.
- R6: When fewer than BUNDLE slots are pending, a message carrying the pending count is released TIMEOUT edges after the first pending pop. Its credits become usable TIMEOUT+LINK_DELAY edges after that pop.
- R7: The credits in a return message are added to the pool before the send decision in the same cycle. In the cycle the message arrives, `in_ready` is 1 even if the pool was empty.
- R8: The transmit pool never holds more than DEPTH credits. After a full drain it accepts exactly DEPTH flits again.
- R9: The receive FIFO is never written while full without a read in the same cycle.
- R10: A return message carries a count from 1 to BUNDLE in a 4-bit field, so DEPTH and BUNDLE are at most 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Producer offers a flit |
| in_ready | output | 1 | Transmit half can accept a flit this cycle |
| in_data | input | DATA_W | Flit offered by the producer |
| out_valid | output | 1 | Receive FIFO holds a flit |
| out_ready | input | 1 | Consumer takes the flit this cycle |
| out_data | output | DATA_W | Flit at the head of the receive FIFO |

## Verification
An accepted flit reaches `out_data` two edges after acceptance: one for the forward link register and one for the FIFO write. The scoreboard pops its queue only on output handshakes, so order and content are checked whatever the latency. Credit results are checked cycle by cycle with the default parameters (BUNDLE 3, TIMEOUT 6, LINK_DELAY 4). For a single pop at edge E, the bench samples `in_ready` low at every falling edge after E through E+9 and high after E+10. For three back-to-back pops ending at edge E, it samples low through E+3 and high after E+4. All samples are taken on falling edges, half a period away from the edges that change the state.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    // width of the credit count carried by one return message
    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        BND_IDLE,
        BND_GATHER,
        BND_EMIT
    } bnd_state_t;

    typedef enum logic {
        SND_RUN,
        SND_WAIT
    } snd_state_t;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] cnt;
    } credit_msg_t;

endpackage

// File: rtl/cfc_sender.sv
module cfc_sender
    import cfc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  credit_msg_t       cred_in,
    output logic              link_valid,
    output logic [DATA_W-1:0] link_data
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] POOL_INIT = CNT_W'(DEPTH);

    snd_state_t       state_q, state_d;
    logic [CNT_W-1:0] pool_q, pool_d;
    logic [SUM_W-1:0] arrive, avail, avail_left;
    logic             fire;

    // returned credits join the pool before the send decision
    always_comb begin
        arrive     = cred_in.valid ? SUM_W'(cred_in.cnt) : '0;
        avail      = SUM_W'(pool_q) + arrive;
        in_ready   = (state_q == SND_RUN) || (arrive != '0);
        fire       = in_valid && in_ready;
        avail_left = avail - SUM_W'(fire);
        pool_d     = avail_left[CNT_W-1:0];
        unique case (state_q)
            SND_RUN:  state_d = (avail_left == '0) ? SND_WAIT : SND_RUN;
            SND_WAIT: state_d = (avail_left == '0) ? SND_WAIT : SND_RUN;
            default:  state_d = SND_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= (DEPTH == 0) ? SND_WAIT : SND_RUN;
            pool_q  <= POOL_INIT;
        end else begin
            state_q <= state_d;
            pool_q  <= pool_d;
        end
    end

    // forward link register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_valid <= 1'b0;
            link_data  <= '0;
        end else begin
            link_valid <= fire;
            if (fire) link_data <= in_data;
        end
    end

    // R8
    pool_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= SUM_W'(DEPTH));

    // R7
    refill_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cred_in.valid && cred_in.cnt != '0) |-> in_ready);

    // R2
    spend_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cred_in.valid) |=> (SUM_W'(pool_q) == $past(avail) - 1'b1));

endmodule

// File: rtl/cfc_fifo.sv
module cfc_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              freed
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_q, wr_q;
    logic [CNT_W-1:0]  fill_q;
    logic              pop;

    always_comb begin
        out_valid = (fill_q != '0);
        out_data  = mem[rd_q];
        pop       = out_valid && out_ready;
        freed     = pop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= '0;
            wr_q   <= '0;
            fill_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            fill_q <= fill_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_data;
    end

    // R9
    fifo_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (fill_q < CNT_W'(DEPTH) || pop));

endmodule

// File: rtl/cfc_bundler.sv
module cfc_bundler
    import cfc_pkg::*;
#(
    parameter int BUNDLE  = 3,
    parameter int TIMEOUT = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        freed,
    output credit_msg_t msg_out
);
    localparam int SUM_W = CNT_W + 1;
    localparam int TMR_W = $clog2(TIMEOUT + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

    bnd_state_t       state_q, state_d;
    logic [CNT_W-1:0] pend_q, pend_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic [SUM_W-1:0] sum;
    logic             timed_out, release_now;

    always_comb begin
        sum         = SUM_W'(pend_q) + SUM_W'(freed);
        timed_out   = (state_q == BND_GATHER) && (tmr_q == TMR_LAST);
        release_now = (sum != '0) && ((sum >= SUM_W'(BUNDLE)) || timed_out);
        state_d     = state_q;
        pend_d      = pend_q;
        cnt_d       = cnt_q;
        tmr_d       = tmr_q;
        unique case (state_q)
            BND_IDLE, BND_EMIT: begin
                tmr_d = '0;
                if (release_now) begin
                    state_d = BND_EMIT;
                    cnt_d   = sum[CNT_W-1:0];
                    pend_d  = '0;
                end else if (sum != '0) begin
                    state_d = BND_GATHER;
                    pend_d  = sum[CNT_W-1:0];
                end else begin
                    state_d = BND_IDLE;
                end
            end
            BND_GATHER: begin
                if (release_now) begin
                    state_d = BND_EMIT;
                    cnt_d   = sum[CNT_W-1:0];
                    pend_d  = '0;
                    tmr_d   = '0;
                end else begin
                    pend_d  = sum[CNT_W-1:0];
                    tmr_d   = tmr_q + 1'b1;
                end
            end
            default: begin
                state_d = BND_IDLE;
                pend_d  = '0;
                tmr_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BND_IDLE;
            pend_q  <= '0;
            cnt_q   <= '0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            cnt_q   <= cnt_d;
            tmr_q   <= tmr_d;
        end
    end

    // outputs
    always_comb begin
        msg_out.valid = (state_q == BND_EMIT);
        msg_out.cnt   = (state_q == BND_EMIT) ? cnt_q : '0;
    end

    // R10
    bundle_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BND_EMIT) |-> (cnt_q != '0 && cnt_q <= CNT_W'(BUNDLE)));

    // R6
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BND_GATHER) |-> (tmr_q < TMR_W'(TIMEOUT) && pend_q != '0));

    // R5
    threshold_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != BND_EMIT && sum >= SUM_W'(BUNDLE)) |=> (state_q == BND_EMIT));

endmodule

// File: rtl/cfc_credit_pipe.sv
module cfc_credit_pipe
    import cfc_pkg::*;
#(
    parameter int LINK_DELAY = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  credit_msg_t msg_in,
    output credit_msg_t msg_out
);
    credit_msg_t stg_q [LINK_DELAY];

    for (genvar i = 0; i < LINK_DELAY; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= msg_in;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign msg_out = stg_q[LINK_DELAY-1];

endmodule

// File: rtl/cfc_link.sv
module cfc_link
    import cfc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 8,
    parameter int BUNDLE     = 3,
    parameter int TIMEOUT    = 6,
    parameter int LINK_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    credit_msg_t       ret_msg, ret_arrive;
    logic              link_valid, freed;
    logic [DATA_W-1:0] link_data;

    cfc_sender #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_sender (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .cred_in    (ret_arrive),
        .link_valid (link_valid),
        .link_data  (link_data)
    );

    cfc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (link_valid),
        .push_data (link_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .freed     (freed)
    );

    cfc_bundler #(.BUNDLE(BUNDLE), .TIMEOUT(TIMEOUT)) u_bundler (
        .clk     (clk),
        .rst_n   (rst_n),
        .freed   (freed),
        .msg_out (ret_msg)
    );

    cfc_credit_pipe #(.LINK_DELAY(LINK_DELAY)) u_ret_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .msg_in  (ret_msg),
        .msg_out (ret_arrive)
    );

endmodule

// File: tb/cfc_link_test.sv
module cfc_link_test;
    localparam int DW = 8;
    localparam int N  = 8;
    localparam int B  = 3;
    localparam int T  = 6;
    localparam int L  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;

    int total = 0;
    int bad   = 0;
    int acc   = 0;
    int seq   = 0;
    int cyc   = 0;
    logic [DW-1:0] sb_q [$];

    always #2.5 clk = ~clk;

    cfc_link #(.DATA_W(DW), .DEPTH(N), .BUNDLE(B), .TIMEOUT(T), .LINK_DELAY(L)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // data presented by the producer changes only on falling edges
    always @(negedge clk) in_data = DW'(seq * 37 + 5);

    // driver side: every accepted flit is pushed as an expected item
    always @(posedge clk) begin
        cyc++;
        if (rst_n && in_valid && in_ready) begin
            sb_q.push_back(in_data);
            acc++;
            seq++;
        end
    end

    // monitor: R4 order and content
    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R4 unexpected flit", int'(out_data), -1);
            end else begin
                check(out_data == sb_q[0], "R4 flit order", int'(out_data), int'(sb_q[0]));
                void'(sb_q.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        #100000;
        check(1'b0, "watchdog", cyc, 20000);
        finish_run();
    end

    task automatic nwait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int a0;
        nwait(3);
        // R1: reset state
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        rst_n = 1'b1;
        nwait(2);
        check(in_ready == 1'b1, "R1 in_ready out of reset", in_ready, 1);

        // R2: exactly N accepted without draining
        in_valid = 1'b1;
        nwait(N + 6);
        check(acc == N, "R2 accepted with full window", acc, N);
        // R3: stalled, nothing accepted while empty
        check(in_ready == 1'b0, "R3 in_ready at zero credits", in_ready, 0);
        a0 = acc;
        nwait(4);
        check(acc == a0, "R3 no accept at zero credits", acc, a0);

        // R6/R7: single pop, released by timeout
        out_ready = 1'b1;
        @(negedge clk);              // pop at the edge just passed (E)
        out_ready = 1'b0;
        for (int k = 0; k < T + L; k++) begin
            if (k > 0) @(negedge clk);
            check(in_ready == 1'b0, "R6 in_ready before timeout return", in_ready, 0);
        end
        @(negedge clk);
        check(in_ready == 1'b1, "R7 in_ready on timeout return", in_ready, 1);
        a0 = acc;
        nwait(3);
        check(acc == a0 + 1, "R6 one credit from timeout", acc, a0 + 1);
        check(in_ready == 1'b0, "R3 in_ready after one credit", in_ready, 0);

        // R5: three pops released by threshold
        out_ready = 1'b1;
        nwait(3);                    // pops at E, E+1, E+2
        out_ready = 1'b0;
        for (int k = 0; k < L; k++) begin
            if (k > 0) @(negedge clk);
            check(in_ready == 1'b0, "R5 in_ready before bundle return", in_ready, 0);
        end
        @(negedge clk);
        check(in_ready == 1'b1, "R5 in_ready on bundle return", in_ready, 1);
        a0 = acc;
        nwait(6);
        check(acc == a0 + B, "R5 bundle credit count", acc, a0 + B);

        // R4/R8: full drain, then pool back to exactly N
        in_valid  = 1'b0;
        out_ready = 1'b1;
        nwait(60);
        check(sb_q.size() == 0, "R4 queue empty after drain", sb_q.size(), 0);
        check(out_valid == 1'b0, "R4 out_valid after drain", out_valid, 0);
        check(in_ready == 1'b1, "R8 in_ready after drain", in_ready, 1);
        out_ready = 1'b0;
        a0 = acc;
        in_valid = 1'b1;
        nwait(N + 8);
        check(acc == a0 + N, "R8 refill caps at depth", acc, a0 + N);

        // R4/R9: streaming with an irregular consumer
        for (int i = 0; i < 120; i++) begin
            out_ready = ((i % 3) != 0) || ((i % 7) == 0);
            @(negedge clk);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        nwait(60);
        check(sb_q.size() == 0, "R9 all streamed flits delivered", sb_q.size(), 0);
        check(acc > a0 + N + 40, "R4 streaming progress", acc, a0 + N + 40);
        check(in_ready == 1'b1, "R8 pool restored after stream", in_ready, 1);
        finish_run();
    end

endmodule